// File: doc/BRIEF.md
# JTAG Bit-Sequence Shifter

This block clocks a JTAG port through a run of between 1 and 64 TCK cycles that the host asks for. A command carries a six-bit cycle count, the level to hold on TMS for the whole run, and a flag that asks for TDO to be captured. The block pulls TDI bytes from a ready/valid byte stream. It shifts them out least significant bit first, one bit per TCK cycle. When capture is on, it packs the sampled TDO bits into bytes in the same order and hands them off on a second ready/valid stream.

TCK timing comes from a programmable half-period, counted in system clocks. Each cycle of a run goes the same way: TDI and the falling edge of TCK leave the block together, the low phase lasts one half-period, TDO is sampled at its end, and a high phase of at least one half-period follows. TCK rests high between runs. It also stays high while the block waits for an input byte or for the consumer of an output byte. A TAP-level sequencer issues runs one after another to walk the state machine and to shift instruction and data registers.

Top module: `jtag_seq_shifter`

## Requirements
- R1: A command is accepted at a clock edge where `cmd_valid` is high and `busy` is low, and `busy` is high in the next cycle. The run produces exactly `cmd_count` rising TCK edges, and a count of 0 produces 64.
- R2: `tms` takes the value of `cmd_tms` at acceptance and holds it through every cycle of the run.
- R3: Run bit k is driven on `tdi` from bit k mod 8 of input byte k/8. A run of n bits consumes exactly ceil(n/8) input bytes, and the upper bits of a partial last byte are never driven.
- R4: `tdi` changes only in the system clock cycle where `tck` falls. With H equal to `cfg_half_period`, and 0 taken as 1, every low phase lasts exactly H system clocks. Every high phase lasts at least H system clocks, and exactly H between two bits of the same byte.
- R5: The value on `tdo_in` in the last system clock of the low phase of run bit k is placed at bit k mod 8 of output byte k/8.
- R6: In a partial last output byte, the bit positions beyond the run's final bit read as 0.
- R7: When `cmd_capture` was 0 at acceptance, `tdo_valid` stays low for the whole run.
- R8: `busy` stays high until the last output byte has been handed off, or until the last high phase ends when capture is off. A `cmd_valid` that arrives while `busy` is high is ignored and starts no run.
- R9: When an input byte is needed and `tdi_valid` is low, `tck` stays high and no partial TCK cycle is issued. Shifting resumes once the byte arrives.
- R10: An offered output byte stays valid with unchanged data until `tdo_ready` takes it, and `tck` stays high meanwhile.
- R11: After reset, `tck`, `tms` and `tdi` are 1, and `busy`, `tdo_valid` and `tdi_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_half_period | input | DIV_W | TCK half-period in system clocks (0 acts as 1) |
| cmd_valid | input | 1 | Command request |
| cmd_count | input | CNT_W | Cycle count, 0 means 2**CNT_W |
| cmd_tms | input | 1 | TMS level for the run |
| cmd_capture | input | 1 | Capture TDO into output bytes |
| busy | output | 1 | Run in progress |
| tdi_data | input | BYTE_W | Input byte |
| tdi_valid | input | 1 | Input byte present |
| tdi_ready | output | 1 | Input byte taken this cycle when valid |
| tdo_data | output | BYTE_W | Captured byte |
| tdo_valid | output | 1 | Captured byte offered |
| tdo_ready | input | 1 | Consumer takes the captured byte |
| tck | output | 1 | JTAG clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo_in | input | 1 | JTAG data from target |

## Verification
The bench sweeps every count from 0 to 63, each with and without capture, so that every partial-byte length is covered. A design that misread a zero count would clock 0 cycles instead of 64. A design that packed bits in the wrong order, or left stale bits in the last byte, would produce output bytes that differ from the computed ones. Further runs starve the input stream in the middle of a run, stall the output consumer, and fire commands at the block while it is busy. A block that lost count across a stall would issue a truncated or extra TCK pulse, and one that accepted a command early would change TMS or the clock count. Low and high phases are timed at several divider values, including 0, so a divider that was off by one shows up in the measured phase lengths.

// File: rtl/jtss_pkg.sv
package jtss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_EMIT  = 3'd4
    } jtss_state_e;
endpackage

// File: rtl/jtss_half_timer.sv
module jtss_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_period,
    input  logic             phase_start,
    output logic             phase_done
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    // A zero setting behaves like a single clock per phase.
    always_comb begin
        limit      = (half_period == '0) ? DIV_W'(1) : half_period;
        phase_done = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, limit};
        if (phase_start)
            cnt_d = '0;
        else if (phase_done)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/jtss_tdo_packer.sv
module jtss_tdo_packer #(
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              samp_en,
    input  logic [IDX_W-1:0]  samp_idx,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_q
);
    logic [BYTE_W-1:0] byte_d;

    // Clearing before each byte keeps unfilled positions at zero.
    always_comb begin
        byte_d = byte_q;
        if (clear)
            byte_d = '0;
        else if (samp_en)
            byte_d[samp_idx] = bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byte_q <= '0;
        else
            byte_q <= byte_d;
    end
endmodule

// File: rtl/jtss_ctrl.sv
module jtss_ctrl
    import jtss_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int BYTE_W = 8,
    localparam int IDX_W  = $clog2(BYTE_W),
    localparam int LEFT_W = CNT_W + 1,
    localparam int FULL_RUN = 1 << CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_tms,
    input  logic              cmd_capture,
    input  logic [BYTE_W-1:0] tdi_data,
    input  logic              tdi_valid,
    output logic              tdi_ready,
    output logic              tdo_valid,
    input  logic              tdo_ready,
    input  logic              phase_done,
    output logic              phase_start,
    output logic              samp_en,
    output logic [IDX_W-1:0]  samp_idx,
    output logic              pack_clear,
    output logic              busy,
    output logic              tck,
    output logic              tms,
    output logic              tdi
);
    typedef struct packed {
        jtss_state_e       st;
        logic [LEFT_W-1:0] left;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] txb;
        logic              cap;
        logic              tms;
        logic              tck;
        logic              tdi;
    } regs_t;

    regs_t r_d, r_q;
    logic             last_in_byte;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        r_d          = r_q;
        tdi_ready    = 1'b0;
        tdo_valid    = 1'b0;
        phase_start  = 1'b0;
        samp_en      = 1'b0;
        pack_clear   = 1'b0;
        nxt_idx      = r_q.idx + IDX_W'(1);
        last_in_byte = (r_q.idx == IDX_W'(BYTE_W - 1)) || (r_q.left == LEFT_W'(1));

        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.left   = (cmd_count == '0) ? LEFT_W'(FULL_RUN) : {1'b0, cmd_count};
                    r_d.tms    = cmd_tms;
                    r_d.cap    = cmd_capture;
                    r_d.idx    = '0;
                    r_d.st     = ST_FETCH;
                    pack_clear = 1'b1;
                end
            end
            ST_FETCH: begin
                tdi_ready = 1'b1;
                if (tdi_valid) begin
                    r_d.txb     = tdi_data;
                    r_d.tdi     = tdi_data[r_q.idx];
                    r_d.tck     = 1'b0;
                    r_d.st      = ST_LOW;
                    phase_start = 1'b1;
                end
            end
            ST_LOW: begin
                if (phase_done) begin
                    samp_en     = r_q.cap;
                    r_d.tck     = 1'b1;
                    r_d.st      = ST_HIGH;
                    phase_start = 1'b1;
                end
            end
            ST_HIGH: begin
                if (phase_done) begin
                    r_d.left = r_q.left - LEFT_W'(1);
                    if (last_in_byte) begin
                        r_d.idx = '0;
                        if (r_q.cap)
                            r_d.st = ST_EMIT;
                        else if (r_q.left == LEFT_W'(1))
                            r_d.st = ST_IDLE;
                        else
                            r_d.st = ST_FETCH;
                    end else begin
                        r_d.idx     = nxt_idx;
                        r_d.tdi     = r_q.txb[nxt_idx];
                        r_d.tck     = 1'b0;
                        r_d.st      = ST_LOW;
                        phase_start = 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                tdo_valid = 1'b1;
                if (tdo_ready) begin
                    pack_clear = 1'b1;
                    r_d.st     = (r_q.left == '0) ? ST_IDLE : ST_FETCH;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.left <= '0;
            r_q.idx  <= '0;
            r_q.txb  <= '0;
            r_q.cap  <= 1'b0;
            r_q.tms  <= 1'b1;
            r_q.tck  <= 1'b1;
            r_q.tdi  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign samp_idx = r_q.idx;
    assign busy     = (r_q.st != ST_IDLE);
    assign tck      = r_q.tck;
    assign tms      = r_q.tms;
    assign tdi      = r_q.tdi;
endmodule

// File: rtl/jtag_seq_shifter.sv
module jtag_seq_shifter #(
    parameter int CNT_W  = 6,
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half_period,
    input  logic              cmd_valid,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_tms,
    input  logic              cmd_capture,
    output logic              busy,
    input  logic [BYTE_W-1:0] tdi_data,
    input  logic              tdi_valid,
    output logic              tdi_ready,
    output logic [BYTE_W-1:0] tdo_data,
    output logic              tdo_valid,
    input  logic              tdo_ready,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo_in
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic             phase_done;
    logic             phase_start;
    logic             samp_en;
    logic [IDX_W-1:0] samp_idx;
    logic             pack_clear;

    jtss_ctrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_count  (cmd_count),
        .cmd_tms    (cmd_tms),
        .cmd_capture(cmd_capture),
        .tdi_data   (tdi_data),
        .tdi_valid  (tdi_valid),
        .tdi_ready  (tdi_ready),
        .tdo_valid  (tdo_valid),
        .tdo_ready  (tdo_ready),
        .phase_done (phase_done),
        .phase_start(phase_start),
        .samp_en    (samp_en),
        .samp_idx   (samp_idx),
        .pack_clear (pack_clear),
        .busy       (busy),
        .tck        (tck),
        .tms        (tms),
        .tdi        (tdi)
    );

    jtss_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_period(cfg_half_period),
        .phase_start(phase_start),
        .phase_done (phase_done)
    );

    jtss_tdo_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pack_clear),
        .samp_en (samp_en),
        .samp_idx(samp_idx),
        .bit_in  (tdo_in),
        .byte_q  (tdo_data)
    );
endmodule

// File: rtl/jtss_checker.sv
module jtss_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic              tdi_valid,
    input logic              tdi_ready,
    input logic              tdo_valid,
    input logic              tdo_ready,
    input logic [BYTE_W-1:0] tdo_data
);
    AST_TMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tms)); // R2

    AST_TDI_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> $fell(tck)); // R4

    AST_STREAMS_NEED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tdi_ready || tdo_valid) |-> busy); // R8

    AST_IDLE_TCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tck); // R9

    AST_STARVE_TCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tdi_ready && !tdi_valid) |-> tck); // R9

    AST_TDO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tdo_valid && !tdo_ready) |=> (tdo_valid && $stable(tdo_data))); // R10

    AST_EMIT_TCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_valid |-> tck); // R10
endmodule

bind jtag_seq_shifter jtss_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .tdi_valid(tdi_valid),
    .tdi_ready(tdi_ready),
    .tdo_valid(tdo_valid),
    .tdo_ready(tdo_ready),
    .tdo_data (tdo_data)
);

// File: tb/sim_jtag_seq_shifter.sv
`timescale 1ns/1ps
module sim_jtag_seq_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_half_period = 8'd1;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_count = '0;
    logic       cmd_tms = 1'b0;
    logic       cmd_capture = 1'b0;
    logic       busy;
    logic [7:0] tdi_data = '0;
    logic       tdi_valid = 1'b0;
    logic       tdi_ready;
    logic [7:0] tdo_data;
    logic       tdo_valid;
    logic       tdo_ready = 1'b0;
    logic       tck, tms, tdi;
    logic       tdo_in = 1'b0;

    always #2 clk = ~clk;

    jtag_seq_shifter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_half_period(cfg_half_period),
        .cmd_valid(cmd_valid), .cmd_count(cmd_count), .cmd_tms(cmd_tms),
        .cmd_capture(cmd_capture), .busy(busy),
        .tdi_data(tdi_data), .tdi_valid(tdi_valid), .tdi_ready(tdi_ready),
        .tdo_data(tdo_data), .tdo_valid(tdo_valid), .tdo_ready(tdo_ready),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo_in(tdo_in)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Run context
    logic [7:0] src [8];
    logic [7:0] rx [8];
    int  nbits, nbytes, seed, heff;
    bit  run_tms, run_cap, starve_mode, bp_mode, in_run = 1'b0;
    int  sidx, nrx, rise_cnt, lowcnt, hicnt, stall_left, tdo_seen, nrx_at_fall, mcyc;
    bit  src_pend, snk_pend, prev_tck, prev_tdi, prev_busy;
    logic [7:0] snk_data;

    function automatic bit tdo_pat(input int s, input int k);
        return ((k * 7 + s * 3) % 11) > 5;
    endfunction

    always @(negedge clk) begin
        if (rst_n && in_run) begin
            if (prev_busy && !busy) nrx_at_fall = nrx + (snk_pend ? 1 : 0);
            prev_busy = busy;
            // output sink
            if (snk_pend) begin
                if (nrx < 8) rx[nrx] = snk_data;
                nrx++;
            end
            tdo_ready = bp_mode ? (mcyc % 5 == 4) : 1'b1;
            snk_pend  = tdo_valid && tdo_ready;
            snk_data  = tdo_data;
            if (tdo_valid) tdo_seen++;
            // input source
            if (src_pend) sidx++;
            tdi_valid = (sidx < nbytes);
            tdi_data  = src[(sidx < 8) ? sidx : 0];
            if (starve_mode && sidx == 1 && stall_left > 0) begin
                tdi_valid = 1'b0;
                stall_left--;
                if (stall_left == 0)
                    chk(rise_cnt == 8, "R9 clocks issued during starvation", rise_cnt, 8);
            end
            src_pend = tdi_valid && tdi_ready;
            if (tdi_ready && !tdi_valid)
                chk(tck == 1'b1, "R9 tck high while starved", int'(tck), 1);
            // pin timing
            if (tdi != prev_tdi)
                chk(!tck && prev_tck, "R4 tdi moved without tck fall", int'(tck), 0);
            if (tck && !prev_tck) begin
                chk(tdi == src[rise_cnt / 8][rise_cnt % 8], "R3 tdi bit", int'(tdi),
                    int'(src[rise_cnt / 8][rise_cnt % 8]));
                chk(tms == run_tms, "R2 tms level", int'(tms), int'(run_tms));
                chk(lowcnt == heff, "R4 low phase length", lowcnt, heff);
                rise_cnt++;
                hicnt = 1;
            end else if (tck) begin
                hicnt++;
            end
            if (!tck && prev_tck) begin
                if (rise_cnt > 0 && (rise_cnt % 8) != 0)
                    chk(hicnt == heff, "R4 high phase length", hicnt, heff);
                tdo_in = tdo_pat(seed, rise_cnt);
                lowcnt = 1;
            end else if (!tck) begin
                lowcnt++;
            end
            prev_tck = tck;
            prev_tdi = tdi;
            mcyc++;
        end
    end

    task automatic run_seq(input int cnt, input bit t, input bit cap, input int h,
                           input bit starve, input bit bp, input bit refuse);
        logic [7:0] exp_b;
        @(negedge clk);
        seed = seed + 1;
        nbits = (cnt == 0) ? 64 : cnt;
        nbytes = (nbits + 7) / 8;
        for (int j = 0; j < 8; j++) src[j] = 8'((seed * 37 + j * 101 + 5) & 255);
        heff = (h == 0) ? 1 : h;
        run_tms = t; run_cap = cap; starve_mode = starve; bp_mode = bp;
        sidx = 0; nrx = 0; rise_cnt = 0; lowcnt = 0; hicnt = 0; tdo_seen = 0;
        stall_left = 40; nrx_at_fall = -1; mcyc = 0;
        src_pend = 0; snk_pend = 0; prev_tck = tck; prev_tdi = tdi; prev_busy = 1'b0;
        cfg_half_period = 8'(h);
        in_run = 1'b1;
        cmd_valid = 1'b1; cmd_count = 6'(cnt); cmd_tms = t; cmd_capture = cap;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        if (refuse) begin
            repeat (10) @(negedge clk);
            cmd_valid = 1'b1; cmd_count = 6'd3; cmd_tms = ~t; cmd_capture = ~cap;
            repeat (6) @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 no extra run started", int'(busy), 0);
        chk(rise_cnt == nbits, "R1 tck rising edges", rise_cnt, nbits);
        chk(sidx == nbytes, "R3 input bytes consumed", sidx, nbytes);
        if (cap) begin
            chk(nrx == nbytes, "R8 output byte count", nrx, nbytes);
            chk(nrx_at_fall == nbytes, "R8 busy held until last handoff", nrx_at_fall, nbytes);
            for (int j = 0; j < nbytes && j < nrx; j++) begin
                exp_b = '0;
                for (int b = 0; b < 8; b++)
                    if (j * 8 + b < nbits) exp_b[b] = tdo_pat(seed, j * 8 + b);
                if (j * 8 + 8 > nbits)
                    chk(rx[j] == exp_b, "R6 partial output byte", int'(rx[j]), int'(exp_b));
                else
                    chk(rx[j] == exp_b, "R5 output byte", int'(rx[j]), int'(exp_b));
            end
        end else begin
            chk(tdo_seen == 0, "R7 no output without capture", tdo_seen, 0);
        end
        in_run = 1'b0;
        tdi_valid = 1'b0;
        tdo_ready = 1'b0;
    endtask

    initial begin
        seed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tck == 1'b1, "R11 reset tck", int'(tck), 1);
        chk(tms == 1'b1, "R11 reset tms", int'(tms), 1);
        chk(tdi == 1'b1, "R11 reset tdi", int'(tdi), 1);
        chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
        chk(tdo_valid == 1'b0, "R11 reset tdo_valid", int'(tdo_valid), 0);
        chk(tdi_ready == 1'b0, "R11 reset tdi_ready", int'(tdi_ready), 0);
        for (int c = 0; c < 64; c++)
            for (int cp = 0; cp < 2; cp++)
                run_seq(c, (c % 3) == 0, cp[0], 1, 1'b0, 1'b0, 1'b0);
        run_seq(5, 1'b1, 1'b1, 3, 1'b0, 1'b0, 1'b0);
        run_seq(8, 1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0);
        run_seq(17, 1'b1, 1'b0, 3, 1'b0, 1'b0, 1'b0);
        run_seq(9, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
        run_seq(20, 1'b1, 1'b1, 1, 1'b1, 1'b0, 1'b0);
        run_seq(0, 1'b0, 1'b1, 2, 1'b0, 1'b1, 1'b0);
        run_seq(0, 1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b1);
        run_seq(0, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule